// File: doc/BRIEF.md
# Audio Serial Port Control and Status Registers

This block is the register-facing half of a stereo or multi-slot audio serial port. A simple 32-bit memory-mapped bus with word-aligned byte offsets reaches a write-only command register, a mode register, a status word, separate registers that clear and force status bits, and registers that enable, disable and show the interrupt mask. It also reaches a receive holding register, a transmit holding register and a fixed version word. The serial datapath outside the block reports its events on dedicated inputs: a received word, a free transmit slot, and per-channel receive overruns and transmit underruns.

Each on/off state (receiver, transmitter, clock) moves only through a pair of set and clear strobes. Error flags are sticky. Every error group keeps one summary flag and one bit per channel, and clearing a summary flag also clears all of that group's channel bits. A single interrupt line is high whenever a status bit and its mask bit are both set.

Top module: `aud_ctl_regs`

## Requirements
- R1: After reset, every enable, status bit, mask bit, the mode register and the transmit data read zero, `irq` is low, and offset 0x28 reads the `VERSION` parameter.
- R2: A write to offset 0x00 sets the receiver state with bit 0, clears it with bit 1, sets the clock state with bit 2, clears it with bit 3, sets the transmitter state with bit 4 and clears it with bit 5. The receiver and transmitter states appear at status bits 0 and 4 and on `rx_en`/`tx_en`, and the clock state appears on `ck_en`.
- R3: When the set and clear bits for the same state are written together, the state ends up cleared.
- R4: Bit 7 of a write to offset 0x00 clears, at that clock edge, all enables, all status bits, the mask, the mode register and both holding registers, whatever other bits are written with it.
- R5: An event on `ev_rx_ovr[c]` sets status bit 2 and bit 8+c. An event on `ev_tx_und[c]` sets status bit 6 and bit 20+c. Status offset is 0x08.
- R6: Ones written to offset 0x0C clear those sticky bits (2, 6, 15:8, 27:20). Clearing bit 2 or bit 6 also clears that group's channel bits. Clearing only a channel bit leaves its summary flag set.
- R7: Ones written to offset 0x10 force those sticky bits, and a forced channel bit also sets its summary flag. Bits 0, 1, 4 and 5 written there have no effect.
- R8: An error event in the same cycle as a clear of that bit leaves the bit set.
- R9: Ones written to offset 0x14 set mask bits and ones written to 0x18 clear them. The mask reads at 0x1C and holds only positions that exist in the status word (0x0FF0FF77 for eight channels).
- R10: `irq` is high exactly when the status word AND the mask is nonzero.
- R11: `ev_rx_word` latches `ev_rx_data` into the receive holding register (0x20) and sets status bit 1. A read of 0x20 returns the latched word and clears bit 1, unless a new word arrives in the same cycle, in which case the new word is latched and bit 1 stays set.
- R12: A write to 0x24 drives `tx_data` and clears status bit 5. `ev_tx_take` sets bit 5 and takes priority over a write in the same cycle.
- R13: Offset 0x04 is a read/write mode register whose value drives `mode_cfg`.
- R14: Writes to the status, mask-view and version offsets change nothing. The command, clear, set, enable and disable offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| ev_rx_word | input | 1 | Datapath delivered a received word |
| ev_rx_data | input | 32 | Received word |
| ev_rx_ovr | input | NCH | Per-channel receive overrun pulses |
| ev_tx_take | input | 1 | Datapath consumed the transmit word |
| ev_tx_und | input | NCH | Per-channel transmit underrun pulses |
| rx_en | output | 1 | Receiver enabled |
| tx_en | output | 1 | Transmitter enabled |
| ck_en | output | 1 | Clock generation enabled |
| mode_cfg | output | 32 | Mode register contents |
| tx_data | output | 32 | Transmit holding register contents |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together, that the address is a defined word offset whenever a strobe is high, and that event inputs are single-cycle pulses from the datapath. The bench drives each bus access as a one-cycle strobe set up on the falling edge and never raises both strobes at once. It raises an event together with a bus access only in the scenarios that check the priority between them.

// File: rtl/aud_ctl_pkg.sv
package aud_ctl_pkg;

  // Byte offsets of the register window
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_MODE  = 'h04;
  localparam int OFS_STAT  = 'h08;
  localparam int OFS_SCLR  = 'h0C;
  localparam int OFS_SSET  = 'h10;
  localparam int OFS_IEN   = 'h14;
  localparam int OFS_IDIS  = 'h18;
  localparam int OFS_IMSK  = 'h1C;
  localparam int OFS_RHOLD = 'h20;
  localparam int OFS_THOLD = 'h24;
  localparam int OFS_VER   = 'h28;

  // Command bit positions
  localparam int CB_RX_ON  = 0;
  localparam int CB_RX_OFF = 1;
  localparam int CB_CK_ON  = 2;
  localparam int CB_CK_OFF = 3;
  localparam int CB_TX_ON  = 4;
  localparam int CB_TX_OFF = 5;
  localparam int CB_SRST   = 7;

  // Status bit positions
  localparam int SB_RX_EN  = 0;
  localparam int SB_RX_RDY = 1;
  localparam int SB_RX_OVR = 2;
  localparam int SB_TX_EN  = 4;
  localparam int SB_TX_RDY = 5;
  localparam int SB_TX_UND = 6;
  localparam int SB_RX_CH  = 8;
  localparam int SB_TX_CH  = 20;

  // Next value of an on/off state: the off strobe dominates
  function automatic logic state_next(input logic cur, input logic on, input logic off);
    return off ? 1'b0 : (on ? 1'b1 : cur);
  endfunction

  // Positions of the status word that hold a real bit for nch channels
  function automatic logic [31:0] impl_bits(input int nch);
    logic [31:0] m;
    m = '0;
    m[SB_RX_EN]  = 1'b1;
    m[SB_RX_RDY] = 1'b1;
    m[SB_RX_OVR] = 1'b1;
    m[SB_TX_EN]  = 1'b1;
    m[SB_TX_RDY] = 1'b1;
    m[SB_TX_UND] = 1'b1;
    for (int c = 0; c < nch; c++) begin
      m[SB_RX_CH + c] = 1'b1;
      m[SB_TX_CH + c] = 1'b1;
    end
    return m;
  endfunction

  // Pending interrupt condition
  function automatic logic irq_pending(input logic [31:0] stat, input logic [31:0] mask);
    return |(stat & mask);
  endfunction

endpackage

// File: rtl/aud_cmd_unit.sv
module aud_cmd_unit
  import aud_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       cmd_we,
  input  logic [5:0] cmd_bits,
  output logic       rx_en,
  output logic       tx_en,
  output logic       ck_en
);

  logic [5:0] c;
  assign c = cmd_we ? cmd_bits : 6'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
      ck_en <= 1'b0;
    end else if (srst) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
      ck_en <= 1'b0;
    end else begin
      rx_en <= state_next(rx_en, c[CB_RX_ON], c[CB_RX_OFF]);
      tx_en <= state_next(tx_en, c[CB_TX_ON], c[CB_TX_OFF]);
      ck_en <= state_next(ck_en, c[CB_CK_ON], c[CB_CK_OFF]);
    end
  end

endmodule

// File: rtl/aud_err_group.sv
module aud_err_group #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           srst,
  input  logic           clr_sum,
  input  logic           set_sum,
  input  logic [NCH-1:0] clr_ch,
  input  logic [NCH-1:0] set_ch,
  input  logic [NCH-1:0] ev_ch,
  output logic           sum,
  output logic [NCH-1:0] ch
);

  logic [NCH-1:0] ch_kill;
  logic [NCH-1:0] ch_make;
  assign ch_kill = clr_ch | {NCH{clr_sum}};
  assign ch_make = set_ch | ev_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum <= 1'b0;
      ch  <= '0;
    end else if (srst) begin
      sum <= 1'b0;
      ch  <= '0;
    end else begin
      // setting sources come last so they win over a clear
      sum <= (sum & ~clr_sum) | set_sum | (|ch_make);
      ch  <= (ch & ~ch_kill) | ch_make;
    end
  end

endmodule

// File: rtl/aud_mask_unit.sv
module aud_mask_unit
  import aud_ctl_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srst,
  input  logic        ien_we,
  input  logic        idis_we,
  input  logic [31:0] wdata,
  output logic [31:0] mask_q
);

  localparam logic [31:0] IMPL = impl_bits(NCH);

  logic [31:0] on_bits;
  logic [31:0] off_bits;
  assign on_bits  = ien_we  ? wdata : 32'd0;
  assign off_bits = idis_we ? wdata : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else if (srst)
      mask_q <= '0;
    else
      mask_q <= ((mask_q | on_bits) & ~off_bits) & IMPL;
  end

endmodule

// File: rtl/aud_ctl_regs.sv
module aud_ctl_regs
  import aud_ctl_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter int          NCH     = 8,
  parameter logic [31:0] VERSION = 32'h0000_0211
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_rx_word,
  input  logic [31:0]       ev_rx_data,
  input  logic [NCH-1:0]    ev_rx_ovr,
  input  logic              ev_tx_take,
  input  logic [NCH-1:0]    ev_tx_und,
  output logic              rx_en,
  output logic              tx_en,
  output logic              ck_en,
  output logic [31:0]       mode_cfg,
  output logic [31:0]       tx_data,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_SCLR  = ADDR_W'(OFS_SCLR);
  localparam logic [ADDR_W-1:0] A_SSET  = ADDR_W'(OFS_SSET);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_IDIS  = ADDR_W'(OFS_IDIS);
  localparam logic [ADDR_W-1:0] A_IMSK  = ADDR_W'(OFS_IMSK);
  localparam logic [ADDR_W-1:0] A_RHOLD = ADDR_W'(OFS_RHOLD);
  localparam logic [ADDR_W-1:0] A_THOLD = ADDR_W'(OFS_THOLD);
  localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'(OFS_VER);
  localparam int NGRP = 2;

  // Named decode events
  logic ctrl_we, mode_we, sclr_we, sset_we, ien_we, idis_we, thold_we;
  logic srst_pulse, rx_rd_hit;

  assign ctrl_we    = bus_wr && (bus_addr == A_CTRL);
  assign mode_we    = bus_wr && (bus_addr == A_MODE);
  assign sclr_we    = bus_wr && (bus_addr == A_SCLR);
  assign sset_we    = bus_wr && (bus_addr == A_SSET);
  assign ien_we     = bus_wr && (bus_addr == A_IEN);
  assign idis_we    = bus_wr && (bus_addr == A_IDIS);
  assign thold_we   = bus_wr && (bus_addr == A_THOLD);
  assign srst_pulse = ctrl_we && bus_wdata[CB_SRST];
  assign rx_rd_hit  = bus_rd && (bus_addr == A_RHOLD);

  aud_cmd_unit u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst     (srst_pulse),
    .cmd_we   (ctrl_we),
    .cmd_bits (bus_wdata[5:0]),
    .rx_en    (rx_en),
    .tx_en    (tx_en),
    .ck_en    (ck_en)
  );

  // Error groups: 0 = receive overrun, 1 = transmit underrun
  logic [NGRP-1:0] g_sum;
  logic [NCH-1:0]  g_ch [NGRP];
  logic [NCH-1:0]  g_ev [NGRP];
  assign g_ev[0] = ev_rx_ovr;
  assign g_ev[1] = ev_tx_und;

  for (genvar g = 0; g < NGRP; g++) begin : g_err
    localparam int SP = (g == 0) ? SB_RX_OVR : SB_TX_UND;
    localparam int CP = (g == 0) ? SB_RX_CH  : SB_TX_CH;
    aud_err_group #(.NCH(NCH)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst    (srst_pulse),
      .clr_sum (sclr_we && bus_wdata[SP]),
      .set_sum (sset_we && bus_wdata[SP]),
      .clr_ch  (bus_wdata[CP +: NCH] & {NCH{sclr_we}}),
      .set_ch  (bus_wdata[CP +: NCH] & {NCH{sset_we}}),
      .ev_ch   (g_ev[g]),
      .sum     (g_sum[g]),
      .ch      (g_ch[g])
    );
  end

  logic [31:0] irq_mask;
  aud_mask_unit #(.NCH(NCH)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst_pulse),
    .ien_we  (ien_we),
    .idis_we (idis_we),
    .wdata   (bus_wdata),
    .mask_q  (irq_mask)
  );

  // Ready flags and holding registers
  logic        rx_rdy, tx_rdy;
  logic [31:0] rx_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rdy   <= 1'b0;
      tx_rdy   <= 1'b0;
      rx_hold  <= '0;
      tx_data  <= '0;
      mode_cfg <= '0;
    end else if (srst_pulse) begin
      rx_rdy   <= 1'b0;
      tx_rdy   <= 1'b0;
      rx_hold  <= '0;
      tx_data  <= '0;
      mode_cfg <= '0;
    end else begin
      if (ev_rx_word)     rx_rdy <= 1'b1;
      else if (rx_rd_hit) rx_rdy <= 1'b0;
      if (ev_tx_take)     tx_rdy <= 1'b1;
      else if (thold_we)  tx_rdy <= 1'b0;
      if (ev_rx_word) rx_hold  <= ev_rx_data;
      if (thold_we)   tx_data  <= bus_wdata;
      if (mode_we)    mode_cfg <= bus_wdata;
    end
  end

  // Status word
  logic [31:0] stat_word;
  always_comb begin
    stat_word = '0;
    stat_word[SB_RX_EN]  = rx_en;
    stat_word[SB_RX_RDY] = rx_rdy;
    stat_word[SB_RX_OVR] = g_sum[0];
    stat_word[SB_TX_EN]  = tx_en;
    stat_word[SB_TX_RDY] = tx_rdy;
    stat_word[SB_TX_UND] = g_sum[1];
    stat_word[SB_RX_CH +: NCH] = g_ch[0];
    stat_word[SB_TX_CH +: NCH] = g_ch[1];
  end

  assign irq = irq_pending(stat_word, irq_mask);

  // Read mux
  logic [31:0] rd_sel;
  always_comb begin
    case (bus_addr)
      A_MODE:  rd_sel = mode_cfg;
      A_STAT:  rd_sel = stat_word;
      A_IMSK:  rd_sel = irq_mask;
      A_RHOLD: rd_sel = rx_hold;
      A_VER:   rd_sel = VERSION;
      default: rd_sel = 32'd0;
    endcase
  end
  assign bus_rdata = bus_rd ? rd_sel : 32'd0;

endmodule

// File: rtl/aud_ctl_regs_chk.sv
module aud_ctl_regs_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctrl_we,
  input logic [5:0]     cmd_bits,
  input logic           srst_pulse,
  input logic           rx_rd_hit,
  input logic           ev_rx_word,
  input logic [NCH-1:0] ev_rx_ovr,
  input logic           rx_en,
  input logic           tx_en,
  input logic           ck_en,
  input logic [31:0]    stat_word,
  input logic [31:0]    irq_mask,
  input logic           irq
);

  AST_CK_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && cmd_bits[2] && !cmd_bits[3] && !srst_pulse) |=> ck_en); // R2

  AST_TX_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && cmd_bits[4] && !cmd_bits[5] && !srst_pulse) |=> tx_en); // R2

  AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && cmd_bits[0] && cmd_bits[1]) |=> !rx_en); // R3

  AST_SRST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse |=> (stat_word == 32'd0 && irq_mask == 32'd0 && !ck_en)); // R4

  AST_CH_HAS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_word[8 +: NCH]) |-> stat_word[2]); // R6

  AST_EVENT_OVER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ev_rx_ovr) && !srst_pulse) |=> stat_word[2]); // R8

  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 32'd0) |-> !irq); // R10

  AST_RHOLD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_hit && !ev_rx_word) |=> !stat_word[1]); // R11

endmodule

bind aud_ctl_regs aud_ctl_regs_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_we    (ctrl_we),
  .cmd_bits   (bus_wdata[5:0]),
  .srst_pulse (srst_pulse),
  .rx_rd_hit  (rx_rd_hit),
  .ev_rx_word (ev_rx_word),
  .ev_rx_ovr  (ev_rx_ovr),
  .rx_en      (rx_en),
  .tx_en      (tx_en),
  .ck_en      (ck_en),
  .stat_word  (stat_word),
  .irq_mask   (irq_mask),
  .irq        (irq)
);

// File: tb/sim_aud_ctl_regs.sv
`timescale 1ns/1ps
module sim_aud_ctl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_rx_word = 1'b0;
  logic [31:0] ev_rx_data = '0;
  logic [7:0]  ev_rx_ovr = '0;
  logic        ev_tx_take = 1'b0;
  logic [7:0]  ev_tx_und = '0;
  logic        rx_en, tx_en, ck_en, irq;
  logic [31:0] mode_cfg, tx_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  aud_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_rx_word(ev_rx_word), .ev_rx_data(ev_rx_data), .ev_rx_ovr(ev_rx_ovr),
    .ev_tx_take(ev_tx_take), .ev_tx_und(ev_tx_und),
    .rx_en(rx_en), .tx_en(tx_en), .ck_en(ck_en),
    .mode_cfg(mode_cfg), .tx_data(tx_data), .irq(irq)
  );

  localparam logic [5:0] CTRL = 6'h00, MODE = 6'h04, STAT = 6'h08, SCLR = 6'h0C,
                         SSET = 6'h10, IEN = 6'h14, IDIS = 6'h18, IMSK = 6'h1C,
                         RHOLD = 6'h20, THOLD = 6'h24, VER = 6'h28;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_ovr(input logic [7:0] r, input logic [7:0] t);
    @(negedge clk);
    ev_rx_ovr = r; ev_tx_und = t;
    @(negedge clk);
    ev_rx_ovr = '0; ev_tx_und = '0;
  endtask

  task automatic clean();
    wr(CTRL, 32'h80);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rx_en", {31'd0, rx_en}, 0);
    chk("R1 ck_en", {31'd0, ck_en}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 mode_cfg", mode_cfg, 0);
    chk("R1 tx_data", tx_data, 0);
    rd(STAT, d); chk("R1 status", d, 0);
    rd(IMSK, d); chk("R1 mask", d, 0);
    rd(VER, d);  chk("R1 version", d, 32'h0000_0211);
  endtask

  task automatic t_control();
    logic [31:0] d;
    clean();
    wr(CTRL, 32'h15);
    rd(STAT, d); chk("R2 status after enables", d, 32'h11);
    chk("R2 ck_en on", {31'd0, ck_en}, 1);
    chk("R2 rx_en on", {31'd0, rx_en}, 1);
    wr(CTRL, 32'h08);
    chk("R2 ck_en off", {31'd0, ck_en}, 0);
    wr(CTRL, 32'h20);
    chk("R2 tx_en off", {31'd0, tx_en}, 0);
    wr(CTRL, 32'h03);
    chk("R3 rx both -> off", {31'd0, rx_en}, 0);
    wr(CTRL, 32'h30);
    chk("R3 tx both -> off", {31'd0, tx_en}, 0);
    wr(CTRL, 32'h0C);
    chk("R3 ck both -> off", {31'd0, ck_en}, 0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    clean();
    pulse_ovr(8'h08, 8'h00);
    rd(STAT, d); chk("R5 rx overrun ch3", d, 32'h0000_0804);
    pulse_ovr(8'h00, 8'h81);
    rd(STAT, d); chk("R5 tx underrun ch0,ch7", d, 32'h0810_0844);
    wr(SCLR, 32'h0000_0800);
    rd(STAT, d); chk("R6 clear channel keeps summary", d, 32'h0810_0044);
    wr(SCLR, 32'h0000_0004);
    rd(STAT, d); chk("R6 clear rx summary", d, 32'h0810_0040);
    wr(SCLR, 32'h0000_0040);
    rd(STAT, d); chk("R6 clear tx summary drops channels", d, 0);
  endtask

  task automatic t_set();
    logic [31:0] d;
    clean();
    wr(SSET, 32'h0000_0233);
    rd(STAT, d); chk("R7 forced channel sets summary, low bits ignored", d, 32'h0000_0204);
    chk("R7 rx_en untouched", {31'd0, rx_en}, 0);
    wr(SSET, 32'h0000_0040);
    rd(STAT, d); chk("R7 force tx summary", d, 32'h0000_0244);
    wr(SCLR, 32'h0000_0044);
    rd(STAT, d); chk("R6 clear both summaries", d, 0);
  endtask

  task automatic t_evt_vs_clr();
    logic [31:0] d;
    clean();
    @(negedge clk);
    ev_rx_ovr = 8'h01; bus_wr = 1'b1; bus_addr = SCLR; bus_wdata = 32'h0000_0104;
    @(negedge clk);
    ev_rx_ovr = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd(STAT, d); chk("R8 event beats clear", d, 32'h0000_0104);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    clean();
    wr(SSET, 32'h0000_0004);
    chk("R10 no mask no irq", {31'd0, irq}, 0);
    wr(IEN, 32'h0000_0004);
    rd(IMSK, d); chk("R9 mask enable", d, 32'h4);
    chk("R10 irq raised", {31'd0, irq}, 1);
    wr(IEN, 32'hFFFF_FFFF);
    rd(IMSK, d); chk("R9 mask only real bits", d, 32'h0FF0_FF77);
    wr(IDIS, 32'h0FF0_FF77);
    rd(IMSK, d); chk("R9 mask disable", d, 0);
    chk("R10 irq dropped", {31'd0, irq}, 0);
    wr(IEN, 32'h0000_0040);
    chk("R10 mask without flag", {31'd0, irq}, 0);
    wr(SCLR, 32'h0000_0004);
  endtask

  task automatic t_rx_hold();
    logic [31:0] d;
    clean();
    @(negedge clk);
    ev_rx_word = 1'b1; ev_rx_data = 32'hCAFE_0001;
    @(negedge clk);
    ev_rx_word = 1'b0;
    rd(STAT, d); chk("R11 rx ready set", d, 32'h2);
    rd(RHOLD, d); chk("R11 holding data", d, 32'hCAFE_0001);
    rd(STAT, d); chk("R11 read clears ready", d, 0);
    @(negedge clk);
    ev_rx_word = 1'b1; ev_rx_data = 32'h0000_0005; bus_rd = 1'b1; bus_addr = RHOLD;
    #1 d = bus_rdata;
    @(negedge clk);
    ev_rx_word = 1'b0; bus_rd = 1'b0;
    chk("R11 read returns old word", d, 32'hCAFE_0001);
    rd(STAT, d); chk("R11 new word keeps ready", d, 32'h2);
    rd(RHOLD, d); chk("R11 new word latched", d, 32'h5);
  endtask

  task automatic t_tx_hold();
    logic [31:0] d;
    clean();
    @(negedge clk); ev_tx_take = 1'b1;
    @(negedge clk); ev_tx_take = 1'b0;
    rd(STAT, d); chk("R12 take sets ready", d, 32'h20);
    wr(THOLD, 32'h0000_A5A5);
    chk("R12 tx_data", tx_data, 32'h0000_A5A5);
    rd(STAT, d); chk("R12 write clears ready", d, 0);
    @(negedge clk);
    ev_tx_take = 1'b1; bus_wr = 1'b1; bus_addr = THOLD; bus_wdata = 32'h77;
    @(negedge clk);
    ev_tx_take = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    rd(STAT, d); chk("R12 take beats write", d, 32'h20);
  endtask

  task automatic t_mode_ro();
    logic [31:0] d;
    clean();
    wr(MODE, 32'h1234_5678);
    rd(MODE, d); chk("R13 mode readback", d, 32'h1234_5678);
    chk("R13 mode_cfg", mode_cfg, 32'h1234_5678);
    wr(STAT, 32'hFFFF_FFFF);
    rd(STAT, d); chk("R14 status write ignored", d, 0);
    wr(IMSK, 32'hFF);
    rd(IMSK, d); chk("R14 mask view write ignored", d, 0);
    wr(VER, 32'h0);
    rd(VER, d); chk("R14 version write ignored", d, 32'h0000_0211);
    rd(CTRL, d); chk("R14 command reads zero", d, 0);
    rd(SCLR, d); chk("R14 clear reg reads zero", d, 0);
  endtask

  task automatic t_swrst();
    logic [31:0] d;
    clean();
    wr(CTRL, 32'h15);
    wr(MODE, 32'hABCD);
    wr(THOLD, 32'h99);
    wr(IEN, 32'h44);
    pulse_ovr(8'h02, 8'h04);
    wr(CTRL, 32'h95);
    rd(STAT, d); chk("R4 status cleared", d, 0);
    rd(IMSK, d); chk("R4 mask cleared", d, 0);
    chk("R4 enables cleared", {29'd0, rx_en, tx_en, ck_en}, 0);
    chk("R4 mode cleared", mode_cfg, 0);
    chk("R4 tx_data cleared", tx_data, 0);
    chk("R4 irq low", {31'd0, irq}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_control();
    t_events();
    t_set();
    t_evt_vs_clr();
    t_mask();
    t_rx_hold();
    t_tx_hold();
    t_mode_ro();
    t_swrst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule